// File: doc/BRIEF.md
# Banked Working-Register RAM

This block is the 128-byte internal data store of a small 8-bit controller core. The lowest 32 bytes form four windows of eight working registers. The PSW selects one of these windows as the active one. The next 16 bytes can be reached one bit at a time. The rest is plain scratch space. Each cycle a single request can arrive. It may name a working register by number, name a byte by its 7-bit address, go through R0 or R1 of the active window as a pointer, push or pop through the stack pointer, or read or write one bit of the bit region.

The block also holds the program status word and the 8-bit stack pointer. The core writes the PSW directly. The parity flag in the PSW is not stored from software: it follows the accumulator value, which the core supplies on its own input. Reads are returned through one registered result port. Pointer and stack accesses that fall outside the 128 bytes raise a one-cycle range flag and have no other effect.

Top module: `bkr_top`

## Requirements
- R1: After a synchronous reset, sp_out is 07H and psw_out is 00H while acc_in is 00H.
- R2: A register access (op_kind 1 = read, 2 = write) with number n in op_sel reaches byte 8*bank + n, where bank is psw_out[4:3].
- R3: A direct access (op_kind 3 = read, 4 = write) reaches byte op_addr for every address 00H-7FH. This includes 00H-07H, which always hold bank 0 whatever the selected bank.
- R4: An indirect access (op_kind 5 = read, 6 = write) uses as its address the byte held in R0 of the active bank when op_sel[0] is 0, and in R1 when op_sel[0] is 1.
- R5: When the indirect pointer is 80H or above, range_err is 1 one cycle later, rd_valid stays 0, and no byte is written.
- R6: A push (op_kind 7) first adds one to the stack pointer and then writes op_wdata to the byte at the new pointer. If the new pointer is 80H or above, nothing is written and range_err pulses, but the pointer still moves.
- R7: A pop (op_kind 8) returns the byte at the current pointer and then subtracts one from the pointer. If the pointer is 80H or above, range_err pulses instead of a result, and the pointer still moves.
- R8: A bit access (op_kind 9 = read, 10 = write) with bit address b in op_addr reaches bit b mod 8 of byte 20H + b/8. A bit read returns {7'b0, bit}. A bit write changes only that bit, to op_bit.
- R9: A PSW write stores psw_wdata[7:1]. Of those bits, bits 4:3 are the bank select and bit 7 is carry. psw_wdata[0] is ignored. psw_out[0] is the XOR of all bits of acc_in as sampled one clock earlier, so it is 1 for an odd number of ones.
- R10: A read result appears on rd_data with rd_valid one cycle after the request. A write is visible to a read issued in the next cycle.
- R11: op_kind values 0 and 11-15 change no byte, no pointer and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| op_kind | input | 4 | Request type, encoding in R2-R11 |
| op_sel | input | 3 | Register number, or pointer choice in bit 0 |
| op_addr | input | 7 | Direct byte address or bit address |
| op_wdata | input | 8 | Byte to write or push |
| op_bit | input | 1 | Value for a bit write |
| acc_in | input | 8 | Accumulator value used for parity |
| psw_we | input | 1 | PSW write strobe |
| psw_wdata | input | 8 | New PSW value (bit 0 ignored) |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| range_err | output | 1 | Pointer or stack access beyond 7FH |
| psw_out | output | 8 | Program status word |
| sp_out | output | 8 | Stack pointer |

## Verification
Every byte and bit read, and every out-of-range flag, is due exactly one clock after the edge that takes the request. A driver task computes that outcome from a bench-side model and queues it. A monitor compares queued items against the outputs at the falling edge after that clock, so each result is paired with its request by order alone. Stack pointer and PSW changes are also due one clock after their request or write strobe. The parity bit is due one clock after acc_in changes. The driver reads both at the next falling edge, after that clock has passed.

// File: rtl/bkr_pkg.sv
package bkr_pkg;
  localparam int DW = 8;

  typedef enum logic [3:0] {
    K_NOP    = 4'd0,
    K_RN_RD  = 4'd1,
    K_RN_WR  = 4'd2,
    K_DIR_RD = 4'd3,
    K_DIR_WR = 4'd4,
    K_IND_RD = 4'd5,
    K_IND_WR = 4'd6,
    K_PUSH   = 4'd7,
    K_POP    = 4'd8,
    K_BIT_RD = 4'd9,
    K_BIT_WR = 4'd10
  } op_kind_e;

  // bank select field inside the status word
  localparam int BANK_HI = 4;
  localparam int BANK_LO = 3;
endpackage

// File: rtl/bkr_decode.sv
module bkr_decode
  import bkr_pkg::*;
#(
  parameter int AW       = 7,
  parameter int BIT_BASE = 32
) (
  input  op_kind_e          kind,
  input  logic [2:0]        sel,
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        bank,
  input  logic [DW-1:0]     ptr0,
  input  logic [DW-1:0]     ptr1,
  input  logic [DW-1:0]     sp,
  output logic [AW-1:0]     acc_addr,
  output logic              is_rd,
  output logic              is_wr,
  output logic              is_bit,
  output logic [2:0]        bit_pos,
  output logic              err,
  output logic              sp_we,
  output logic [DW-1:0]     sp_nxt
);
  logic [DW-1:0] ptr;

  always_comb begin
    acc_addr = '0;
    is_rd    = 1'b0;
    is_wr    = 1'b0;
    is_bit   = 1'b0;
    bit_pos  = addr[2:0];
    err      = 1'b0;
    sp_we    = 1'b0;
    sp_nxt   = sp;
    ptr      = sel[0] ? ptr1 : ptr0;
    case (kind)
      K_RN_RD, K_RN_WR: begin
        acc_addr = AW'({bank, sel});
        is_rd    = (kind == K_RN_RD);
        is_wr    = (kind == K_RN_WR);
      end
      K_DIR_RD, K_DIR_WR: begin
        acc_addr = addr;
        is_rd    = (kind == K_DIR_RD);
        is_wr    = (kind == K_DIR_WR);
      end
      K_IND_RD, K_IND_WR: begin
        acc_addr = ptr[AW-1:0];
        err      = (ptr >> AW) != '0;
        is_rd    = (kind == K_IND_RD);
        is_wr    = (kind == K_IND_WR);
      end
      K_PUSH: begin
        sp_nxt   = sp + 1'b1;
        sp_we    = 1'b1;
        acc_addr = sp_nxt[AW-1:0];
        err      = (sp_nxt >> AW) != '0;
        is_wr    = 1'b1;
      end
      K_POP: begin
        sp_nxt   = sp - 1'b1;
        sp_we    = 1'b1;
        acc_addr = sp[AW-1:0];
        err      = (sp >> AW) != '0;
        is_rd    = 1'b1;
      end
      K_BIT_RD, K_BIT_WR: begin
        acc_addr = AW'(BIT_BASE) + AW'(addr[AW-1:3]);
        is_bit   = 1'b1;
        is_rd    = (kind == K_BIT_RD);
        is_wr    = (kind == K_BIT_WR);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bkr_lo_file.sv
module bkr_lo_file #(
  parameter int NBYTES = 48,
  parameter int DW     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [$clog2(NBYTES)-1:0]  waddr,
  input  logic [DW-1:0]              wdata,
  input  logic [$clog2(NBYTES)-1:0]  raddr,
  input  logic [1:0]                 bank,
  output logic [DW-1:0]              rdata,
  output logic [DW-1:0]              ptr0,
  output logic [DW-1:0]              ptr1
);
  localparam int IW = $clog2(NBYTES);

  logic [DW-1:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
  assign ptr0  = mem[IW'({bank, 3'b000})];
  assign ptr1  = mem[IW'({bank, 3'b001})];

  // R2
  lo_wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < NBYTES));
endmodule

// File: rtl/bkr_hi_ram.sv
module bkr_hi_ram #(
  parameter int DEPTH = 80,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [$clog2(DEPTH)-1:0]  waddr,
  input  logic [DW-1:0]             wdata,
  input  logic                      re,
  input  logic [$clog2(DEPTH)-1:0]  raddr,
  output logic [DW-1:0]             rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R3
  hi_wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/bkr_top.sv
module bkr_top
  import bkr_pkg::*;
#(
  parameter int          AW       = 7,
  parameter int          LO_BYTES = 48,
  parameter int          BIT_BASE = 32,
  parameter logic [7:0]  SP_RST   = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_kind,
  input  logic [2:0]    op_sel,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_wdata,
  input  logic          op_bit,
  input  logic [7:0]    acc_in,
  input  logic          psw_we,
  input  logic [7:0]    psw_wdata,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          range_err,
  output logic [7:0]    psw_out,
  output logic [7:0]    sp_out
);
  localparam int MEM_BYTES = 1 << AW;
  localparam int HI_DEPTH  = MEM_BYTES - LO_BYTES;
  localparam int LIW       = $clog2(LO_BYTES);
  localparam int HIW       = $clog2(HI_DEPTH);

  op_kind_e      kind;
  logic [AW-1:0] acc_addr, hi_full;
  logic          is_rd, is_wr, is_bit, err, sp_we;
  logic [2:0]    bit_pos;
  logic [7:0]    sp_nxt, ptr0, ptr1, lo_rd, hi_rd, bit_byte, wr_byte;
  logic          in_lo, do_rd, do_wr;

  logic [7:1]    psw_q;
  logic          par_q;
  logic [7:0]    sp_q;
  logic          rd_valid_q, err_q, sel_hi_q;
  logic [7:0]    lo_val_q;

  assign kind = op_kind_e'(op_kind);

  bkr_decode #(.AW(AW), .BIT_BASE(BIT_BASE)) u_dec (
    .kind(kind), .sel(op_sel), .addr(op_addr),
    .bank(psw_q[BANK_HI:BANK_LO]), .ptr0(ptr0), .ptr1(ptr1), .sp(sp_q),
    .acc_addr(acc_addr), .is_rd(is_rd), .is_wr(is_wr), .is_bit(is_bit),
    .bit_pos(bit_pos), .err(err), .sp_we(sp_we), .sp_nxt(sp_nxt)
  );

  assign in_lo   = acc_addr < AW'(LO_BYTES);
  assign hi_full = acc_addr - AW'(LO_BYTES);
  assign do_rd   = op_valid && is_rd && !err;
  assign do_wr   = op_valid && is_wr && !err;

  always_comb begin
    bit_byte          = lo_rd;
    bit_byte[bit_pos] = op_bit;
  end
  assign wr_byte = is_bit ? bit_byte : op_wdata;

  bkr_lo_file #(.NBYTES(LO_BYTES), .DW(DW)) u_lo (
    .clk(clk), .rst(rst),
    .we(do_wr && in_lo), .waddr(acc_addr[LIW-1:0]), .wdata(wr_byte),
    .raddr(acc_addr[LIW-1:0]), .bank(psw_q[BANK_HI:BANK_LO]),
    .rdata(lo_rd), .ptr0(ptr0), .ptr1(ptr1)
  );

  bkr_hi_ram #(.DEPTH(HI_DEPTH), .DW(DW)) u_hi (
    .clk(clk), .rst(rst),
    .we(do_wr && !in_lo), .waddr(hi_full[HIW-1:0]), .wdata(wr_byte),
    .re(do_rd && !in_lo), .raddr(hi_full[HIW-1:0]), .rdata(hi_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q      <= '0;
      par_q      <= 1'b0;
      sp_q       <= SP_RST;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
      sel_hi_q   <= 1'b0;
      lo_val_q   <= '0;
    end else begin
      par_q      <= ^acc_in;
      if (psw_we) psw_q <= psw_wdata[7:1];
      if (op_valid && sp_we) sp_q <= sp_nxt;
      rd_valid_q <= do_rd;
      err_q      <= op_valid && err && (is_rd || is_wr);
      if (do_rd) begin
        sel_hi_q <= !in_lo;
        lo_val_q <= is_bit ? {7'b0, lo_rd[bit_pos]} : lo_rd;
      end
    end
  end

  assign rd_valid  = rd_valid_q;
  assign range_err = err_q;
  assign rd_data   = sel_hi_q ? hi_rd : lo_val_q;
  assign psw_out   = {psw_q, par_q};
  assign sp_out    = sp_q;

  // R6
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && kind == K_PUSH) |=> (sp_out == $past(sp_out) + 8'd1));
  // R7
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && kind == K_POP) |=> (sp_out == $past(sp_out) - 8'd1));
  // R9
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (psw_out[0] == ^$past(acc_in)));
  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && range_err));
  // R10
  result_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(op_valid));
  // R11
  idle_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || kind > K_BIT_WR) |=> $stable(sp_out));
endmodule

// File: tb/bkr_top_tb_top.sv
`timescale 1ns/1ps
module bkr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_kind = '0;
  logic [2:0] op_sel = '0;
  logic [6:0] op_addr = '0;
  logic [7:0] op_wdata = '0;
  logic       op_bit = 1'b0;
  logic [7:0] acc_in = '0;
  logic       psw_we = 1'b0;
  logic [7:0] psw_wdata = '0;
  logic       rd_valid, range_err;
  logic [7:0] rd_data, psw_out, sp_out;

  always #2 clk = ~clk;

  bkr_top dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_sel(op_sel), .op_addr(op_addr), .op_wdata(op_wdata), .op_bit(op_bit),
    .acc_in(acc_in), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .range_err(range_err),
    .psw_out(psw_out), .sp_out(sp_out)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] m_mem [128];
  logic [7:0] m_sp  = 8'h07;
  logic [7:0] m_psw = 8'h00;

  logic       q_err [$];
  logic [7:0] q_dat [$];
  string      q_req [$];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic       e;
    logic [7:0] d;
    string      r;
    if (!rst && (rd_valid || range_err)) begin
      if (q_err.size() == 0) begin
        chk("R10 unexpected result", {6'b0, rd_valid, range_err}, 8'h00);
      end else begin
        e = q_err.pop_front();
        d = q_dat.pop_front();
        r = q_req.pop_front();
        chk({r, " flags"}, {6'b0, rd_valid, range_err}, {6'b0, !e, e});
        if (!e) chk(r, rd_data, d);
      end
    end
  end

  // driver: model the request, queue its outcome, present it for one cycle
  task automatic do_op(input int k, input int sel, input int a,
                       input logic [7:0] wd, input logic bv, input string req);
    logic [7:0] ptr;
    int pa;
    logic err;
    int bank;
    bank = int'(m_psw[4:3]);
    err = 1'b0;
    pa = 0;
    case (k)
      1, 2: pa = bank * 8 + sel;
      3, 4: pa = a;
      5, 6: begin
        ptr = m_mem[bank * 8 + (sel & 1)];
        if (ptr[7]) err = 1'b1; else pa = int'(ptr);
      end
      7: begin
        m_sp = m_sp + 8'd1;
        if (m_sp[7]) err = 1'b1; else pa = int'(m_sp);
      end
      8: if (m_sp[7]) err = 1'b1; else pa = int'(m_sp);
      9, 10: pa = 32 + (a >> 3);
      default: ;
    endcase
    if (err) begin
      q_err.push_back(1'b1); q_dat.push_back(8'h00); q_req.push_back(req);
    end else if (k == 1 || k == 3 || k == 5 || k == 8 || k == 9) begin
      q_err.push_back(1'b0);
      q_dat.push_back(k == 9 ? {7'b0, m_mem[pa][a & 7]} : m_mem[pa]);
      q_req.push_back(req);
    end else if (k == 10) begin
      m_mem[pa][a & 7] = bv;
    end else if (k == 2 || k == 4 || k == 6 || k == 7) begin
      m_mem[pa] = wd;
    end
    if (k == 8) m_sp = m_sp - 8'd1;
    op_valid = 1'b1;
    op_kind  = 4'(k);
    op_sel   = 3'(sel);
    op_addr  = 7'(a);
    op_wdata = wd;
    op_bit   = bv;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic set_psw(input logic [7:0] v);
    psw_we = 1'b1;
    psw_wdata = v;
    @(negedge clk);
    psw_we = 1'b0;
    m_psw = {v[7:1], 1'b0};
  endtask

  task automatic set_acc(input logic [7:0] v, input logic par, input string req);
    acc_in = v;
    @(negedge clk);
    chk(req, {7'b0, psw_out[0]}, {7'b0, par});
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset sp", sp_out, 8'h07);
    chk("R1 reset psw", psw_out, 8'h00);

    for (int i = 0; i < 32; i++) do_op(4, 0, i, 8'h40 + 8'(i), 1'b0, "R3 fill");

    set_psw(8'h10);
    chk("R9 psw bank2", psw_out, 8'h10);
    do_op(1, 5, 0, 8'h00, 1'b0, "R2 bank2 R5 read");

    set_psw(8'h18);
    do_op(2, 2, 0, 8'hA5, 1'b0, "R2 bank3 R2 write");
    do_op(3, 0, 'h1A, 8'h00, 1'b0, "R10 direct read after register write");
    do_op(1, 2, 0, 8'h00, 1'b0, "R2 bank3 R2 read");
    do_op(3, 0, 'h03, 8'h00, 1'b0, "R3 direct 03 reaches bank0");

    set_psw(8'h08);
    do_op(4, 0, 'h08, 8'h45, 1'b0, "R4 set R0");
    do_op(4, 0, 'h09, 8'h90, 1'b0, "R5 set R1");
    do_op(4, 0, 'h45, 8'h77, 1'b0, "R3 direct write");
    do_op(5, 0, 0, 8'h00, 1'b0, "R4 indirect read via R0");
    do_op(6, 0, 0, 8'h12, 1'b0, "R4 indirect write via R0");
    do_op(3, 0, 'h45, 8'h00, 1'b0, "R4 indirect write landed");
    do_op(5, 1, 0, 8'h00, 1'b0, "R5 indirect read pointer 90");
    do_op(6, 1, 0, 8'hEE, 1'b0, "R5 indirect write pointer 90");
    do_op(3, 0, 'h10, 8'h00, 1'b0, "R5 no write at 10");

    do_op(7, 0, 0, 8'h31, 1'b0, "R6 push");
    chk("R6 sp after push", sp_out, 8'h08);
    do_op(3, 0, 'h08, 8'h00, 1'b0, "R6 pushed byte");
    do_op(8, 0, 0, 8'h00, 1'b0, "R7 pop");
    chk("R7 sp after pop", sp_out, 8'h07);
    for (int i = 0; i < 8; i++) do_op(8, 0, 0, 8'h00, 1'b0, "R7 pop run");
    chk("R7 sp wraps", sp_out, 8'hFF);
    do_op(8, 0, 0, 8'h00, 1'b0, "R7 pop out of range");
    chk("R7 sp moves on error", sp_out, 8'hFE);
    do_op(7, 0, 0, 8'hC3, 1'b0, "R6 push out of range");
    chk("R6 sp moves on error", sp_out, 8'hFF);
    do_op(7, 0, 0, 8'h3C, 1'b0, "R6 push wraps to 00");
    chk("R6 sp at 00", sp_out, 8'h00);
    do_op(3, 0, 'h00, 8'h00, 1'b0, "R6 byte at 00");

    do_op(4, 0, 'h22, 8'h00, 1'b0, "R8 clear byte 22");
    do_op(10, 0, 'h13, 8'h00, 1'b1, "R8 bit write 13");
    do_op(3, 0, 'h22, 8'h00, 1'b0, "R8 byte 22 after bit write");
    do_op(9, 0, 'h13, 8'h00, 1'b0, "R8 bit read 13");
    do_op(9, 0, 'h12, 8'h00, 1'b0, "R8 bit read 12");
    do_op(4, 0, 'h2F, 8'h0F, 1'b0, "R8 fill byte 2F");
    do_op(10, 0, 'h7F, 8'h00, 1'b1, "R8 bit write 7F");
    do_op(10, 0, 'h78, 8'h00, 1'b0, "R8 bit write 78");
    do_op(3, 0, 'h2F, 8'h00, 1'b0, "R8 byte 2F");

    set_psw(8'hFF);
    chk("R9 psw bit0 ignored", psw_out, 8'hFE);
    set_acc(8'h07, 1'b1, "R9 parity odd");
    set_acc(8'h03, 1'b0, "R9 parity even");
    set_acc(8'h80, 1'b1, "R9 parity single bit");

    do_op(4, 0, 'h30, 8'h9A, 1'b0, "R3 scratch write 30");
    do_op(4, 0, 'h7F, 8'h5B, 1'b0, "R3 scratch write 7F");
    do_op(3, 0, 'h30, 8'h00, 1'b0, "R3 scratch read 30");
    do_op(3, 0, 'h7F, 8'h00, 1'b0, "R3 scratch read 7F");
    do_op(4, 0, 'h18, 8'h7F, 1'b0, "R4 bank3 R0 pointer");
    do_op(5, 0, 0, 8'h00, 1'b0, "R4 indirect into scratch");

    do_op(12, 0, 'h30, 8'hDE, 1'b1, "R11 unused code");
    chk("R11 sp unchanged", sp_out, 8'h00);
    do_op(0, 0, 'h30, 8'hDE, 1'b1, "R11 code 0");
    do_op(3, 0, 'h30, 8'h00, 1'b0, "R11 byte 30 unchanged");

    repeat (3) @(negedge clk);
    chk("R10 all results arrived", 8'(q_err.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule